// File: doc/BRIEF.md
# Addressable Tap Shift Register

This block is a serial delay line of `DEPTH` one-bit stages (32 by default) that advance together on each rising clock edge while the enable input is high. A binary tap address selects one stage and presents it on the tap output through a purely combinational multiplexer tree. Holding the address at a fixed value N therefore gives a delay of N+1 enabled clock edges from the serial input to the tap output, with no extra pipeline register. If the address changes, the tap output follows at once, without waiting for a clock edge.

A second output always shows the final stage. Several instances can be chained by feeding this output into the serial input of the next instance, with the clock and enable shared. The stages have no reset. Their power-up contents come from a parameter, in which bit i is the starting value of stage i. `DEPTH` must be a power of two.

Top module: `addr_tap_srl`

## Requirements
- R1: On a rising edge with `shift_en` high, stage 0 captures `ser_in`. Address 0 then returns the bit captured on the most recent enabled edge.
- R2: On each enabled edge, every stage i (for i from 0 to DEPTH-2) passes its bit to stage i+1, and the old last-stage bit is discarded.
- R3: While `shift_en` is low, no stage changes. `tail_out`, and `tap_out` under a fixed address, keep their values across clock edges.
- R4: `tap_out` equals stage `tap_sel` (binary stage index, 0 nearest the input) combinationally. It follows an address change between clock edges whatever the level of `shift_en`.
- R5: With `tap_sel` held at N, a bit on `ser_in` reaches `tap_out` N+1 enabled edges after the edge that captured it. For example, N=7 gives 8 edges.
- R6: `tail_out` always shows stage DEPTH-1, and changes only just after an enabled edge.
- R7: Before any shift, stage i holds bit i of parameter `INIT_BITS` (default all zero). No input clears the stages.
- R8: When `tail_out` of one instance feeds `ser_in` of a second, with clock and enable shared, a bit reaches the second instance's `tap_out` after DEPTH+N+1 enabled edges, where N is that instance's address (38 for N=5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| shift_en | input | 1 | Shift enable; stages hold while low |
| ser_in | input | 1 | Serial data entering stage 0 |
| tap_sel | input | $clog2(DEPTH) | Binary index of the stage shown on `tap_out` |
| tap_out | output | 1 | Combinational read of the selected stage |
| tail_out | output | 1 | Last stage, for chaining instances |

## Verification
A shift and an address change can occur in the same cycle: the address moves between two edges while enable is high, and then the edge shifts the contents under the new address. The bench drives address changes after the falling edge. It checks `tap_out` against the reference queue before the rising edge, where it must show the new address over the old contents, and again just after the edge, where it must show the new address over the shifted contents. Latency runs on a single marker bit confirm the N+1 and DEPTH+N+1 delays, on both a lone instance and a chained pair.

// File: rtl/addr_tap_pkg.sv
package addr_tap_pkg;

    localparam int TAP_DEPTH_DEF = 32;

    typedef struct packed {
        logic en;
        logic bit_in;
    } shift_req_t;

    function automatic int tap_addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic bit is_pow2(input int depth);
        return (depth > 0) && ((depth & (depth - 1)) == 0);
    endfunction

endpackage

// File: rtl/tap_shift_chain.sv
module tap_shift_chain
    import addr_tap_pkg::*;
#(
    parameter int               DEPTH     = TAP_DEPTH_DEF,
    parameter logic [DEPTH-1:0] INIT_BITS = '0
) (
    input  logic             clk,
    input  shift_req_t       req,
    output logic [DEPTH-1:0] stages_o,
    output logic             last_o
);

    // One flop per stage; stage 0 takes the serial input, the rest take their neighbour.
    for (genvar i = 0; i < DEPTH; i++) begin : cell_g
        logic cell_q = INIT_BITS[i];
        logic cell_d;

        if (i == 0) begin : g_head
            assign cell_d = req.bit_in;
        end else begin : g_body
            assign cell_d = stages_o[i-1];
        end

        always_ff @(posedge clk) begin
            if (req.en) begin
                cell_q <= cell_d;
            end
        end

        assign stages_o[i] = cell_q;
    end

    assign last_o = stages_o[DEPTH-1];

endmodule

// File: rtl/tap_read_tree.sv
module tap_read_tree
    import addr_tap_pkg::*;
#(
    parameter int DEPTH  = TAP_DEPTH_DEF,
    parameter int ADDR_W = tap_addr_bits(DEPTH)
) (
    input  logic [DEPTH-1:0]  stages_i,
    input  logic [ADDR_W-1:0] sel_i,
    output logic              tap_o
);

    // Binary tree of 2:1 selectors; address bit l steers level l.
    for (genvar l = 0; l < ADDR_W; l++) begin : lvl_g
        localparam int W = DEPTH >> (l + 1);
        logic [2*W-1:0] src;
        logic [W-1:0]   dst;

        if (l == 0) begin : g_first
            assign src = stages_i;
        end else begin : g_next
            assign src = lvl_g[l-1].dst;
        end

        for (genvar j = 0; j < W; j++) begin : node_g
            assign dst[j] = sel_i[l] ? src[2*j+1] : src[2*j];
        end
    end

    assign tap_o = lvl_g[ADDR_W-1].dst[0];

endmodule

// File: rtl/addr_tap_srl.sv
module addr_tap_srl
    import addr_tap_pkg::*;
#(
    parameter int               DEPTH     = TAP_DEPTH_DEF,
    parameter logic [DEPTH-1:0] INIT_BITS = '0,
    localparam int              ADDR_W    = tap_addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic [ADDR_W-1:0] tap_sel,
    output logic              tap_out,
    output logic              tail_out
);

    shift_req_t       req;
    logic [DEPTH-1:0] stage_vec;

    assign req.en     = shift_en;
    assign req.bit_in = ser_in;

    tap_shift_chain #(
        .DEPTH     (DEPTH),
        .INIT_BITS (INIT_BITS)
    ) u_chain (
        .clk      (clk),
        .req      (req),
        .stages_o (stage_vec),
        .last_o   (tail_out)
    );

    tap_read_tree #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_tree (
        .stages_i (stage_vec),
        .sel_i    (tap_sel),
        .tap_o    (tap_out)
    );

endmodule

// File: rtl/addr_tap_srl_chk.sv
module addr_tap_srl_chk #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              shift_en,
    input logic              ser_in,
    input logic [ADDR_W-1:0] tap_sel,
    input logic [DEPTH-1:0]  stages,
    input logic              tap_out,
    input logic              tail_out
);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R1
    head_capture_chk: assert property (@(posedge clk) disable iff (!armed)
        shift_en |=> stages[0] == $past(ser_in));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!armed)
        shift_en |=> stages[DEPTH-1:1] == $past(stages[DEPTH-2:0]));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!armed)
        !shift_en |=> $stable(stages));

    // R4
    tap_read_chk: assert property (@(negedge clk) disable iff (!armed)
        tap_out == stages[tap_sel]);

    // R6
    tail_shift_chk: assert property (@(posedge clk) disable iff (!armed)
        shift_en |=> tail_out == $past(stages[DEPTH-2]));

    // R6
    tail_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        !shift_en |=> $stable(tail_out));

endmodule

bind addr_tap_srl addr_tap_srl_chk #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .tap_sel  (tap_sel),
    .stages   (stage_vec),
    .tap_out  (tap_out),
    .tail_out (tail_out)
);

// File: tb/test_addr_tap_srl.sv
`timescale 1ns/1ps
module test_addr_tap_srl;

    localparam logic [31:0] INIT_A = 32'h9E37_79B9;
    localparam int NVEC = 16;
    // {shift_en, ser_in, tap_sel[4:0]}
    localparam logic [6:0] VEC [NVEC] = '{
        7'h60, 7'h41, 7'h62, 7'h00, 7'h63, 7'h5F, 7'h7F, 7'h1F,
        7'h44, 7'h65, 7'h20, 7'h48, 7'h6A, 7'h4F, 7'h70, 7'h5E
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       ce = 1'b0, din = 1'b0;
    logic [4:0] addr = '0, addr_b = '0;
    logic       q, q_last, q_b, q_last_b;

    addr_tap_srl #(.DEPTH(32), .INIT_BITS(INIT_A)) i_addr_tap_srl (
        .clk(clk), .shift_en(ce), .ser_in(din), .tap_sel(addr),
        .tap_out(q), .tail_out(q_last));

    addr_tap_srl #(.DEPTH(32)) i_addr_tap_srl_b (
        .clk(clk), .shift_en(ce), .ser_in(q_last), .tap_sel(addr_b),
        .tap_out(q_b), .tail_out(q_last_b));

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] ref_a = INIT_A, ref_b = '0;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Called just after a falling edge; returns just after the next falling edge.
    task automatic edge_step(input logic c, input logic d, input logic [4:0] a, input logic [4:0] ab);
        ce = c; din = d; addr = a; addr_b = ab;
        #1;
        chk("R4 tap before edge", q, ref_a[a]);
        chk("R8 chained tap before edge", q_b, ref_b[ab]);
        @(posedge clk);
        if (c) begin
            ref_b = {ref_b[30:0], ref_a[31]};
            ref_a = {ref_a[30:0], d};
        end
        #1;
        chk("R2 tap after edge", q, ref_a[a]);
        chk("R6 tail after edge", q_last, ref_a[31]);
        chk("R8 chained tap after edge", q_b, ref_b[ab]);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R1..all watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic sv_tail, sv_tap;
        int lat_a, lat_b;

        // R7: power-up contents, swept through the tap before any shift
        @(negedge clk);
        chk("R7 initial tail", q_last, INIT_A[31]);
        for (int i = 0; i < 32; i++) begin
            addr = 5'(i);
            #0.1;
            chk("R7 initial stage via tap", q, INIT_A[i]);
        end
        @(negedge clk);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            edge_step(VEC[v][6], VEC[v][5], VEC[v][4:0], VEC[v][4:0] ^ 5'h1F);
        end

        // R1: address 0 shows the last captured bit
        edge_step(1'b1, 1'b1, 5'd0, 5'd0);
        chk("R1 head after 1", q, 1'b1);
        edge_step(1'b1, 1'b0, 5'd0, 5'd0);
        chk("R1 head after 0", q, 1'b0);

        // R3: hold with enable low
        edge_step(1'b1, 1'b1, 5'd9, 5'd3);
        sv_tail = q_last; sv_tap = q;
        for (int k = 0; k < 3; k++) edge_step(1'b0, ~din, 5'd9, 5'd3);
        chk("R3 tail held", q_last, sv_tail);
        chk("R3 tap held", q, sv_tap);

        // R4: address moves between edges, enable high and low, no edge in between
        for (int pass = 0; pass < 2; pass++) begin
            ce = pass[0];
            for (int i = 0; i < 32; i += 5) begin
                addr = 5'(31 - i);
                #0.5;
                chk("R4 live address change", q, ref_a[31 - i]);
            end
            edge_step(ce, 1'b1, 5'd12, 5'd20);
        end

        // Random traffic with mid-cycle address changes
        for (int n = 0; n < 600; n++) begin
            logic [4:0] pre;
            pre = 5'($urandom);
            addr = pre;
            #0.5;
            chk("R4 random mid-cycle tap", q, ref_a[pre]);
            #0.5;
            edge_step(($urandom % 4) != 0, 1'($urandom), 5'($urandom), 5'($urandom));
        end

        // R5 and R8: marker latency on a single and a chained instance
        for (int k = 0; k < 64; k++) edge_step(1'b1, 1'b0, 5'd7, 5'd5);
        lat_a = 0; lat_b = 0;
        for (int k = 1; k <= 45; k++) begin
            edge_step(1'b1, k == 1, 5'd7, 5'd5);
            if (q === 1'b1 && lat_a == 0) lat_a = k;
            if (q_b === 1'b1 && lat_b == 0) lat_b = k;
        end
        chk_int("R5 delay with address 7", lat_a, 8);
        chk_int("R8 chained delay with address 5", lat_b, 38);

        finish_run();
    end

endmodule